// File: doc/BRIEF.md
# Pipeline Interlock and Forwarding Unit

This block is the hazard controller for an in-order pipeline with five single-cycle stages: fetch, decode with register read, execute, memory access and write-back. In every cycle it looks at the instruction class and register fields held in the decode latch and in the three later pipeline latches. From these it decides whether fetch and decode must hold while a bubble enters execute. It also sets the operand-source selects for the execute stage and raises per-operand flags that let decode take a register value in the same cycle that write-back is writing it.

A two-bit policy input selects how aggressive the unit is. In plain mode there is no forwarding and the register file is not split, so a dependent instruction decodes only in the cycle after its producer's write-back. In split mode the register file writes in the first half of the cycle and reads in the second half. In forward mode, ALU results and loaded data are routed back into execute, and split access is also on. In every mode the data operand of a store is taken only from the decode-stage register read and is never forwarded. The datapath, the register file and the memories are outside the block.

Top module: `hazard_ctl`

## Requirements
- R1: While `rst` is high, all hold, bubble and write-through outputs are 0 and both selects are 00, whatever the other inputs are.
- R2: Policy encoding: `mode` 00 is plain, 01 is split, and 10 or 11 is forward. In plain mode, decode stalls while the execute, memory or write-back latch has its write enable set and a destination equal to a source that the decode instruction reads.
- R3: In split mode, a match in the execute or memory latch stalls decode. A match only in the write-back latch does not stall and raises that operand's write-through flag instead.
- R4: In forward mode, an operand that may be forwarded stalls decode only when the execute latch holds a load (class 10) that writes the matching register.
- R5: The data operand of a store (class 11, second source) is never forwardable. In split and forward mode it stalls decode on a match in the execute or memory latch, even when the producer is an ALU operation.
- R6: Select encoding: 01 takes the value from the execute/memory latch, 10 takes it from the memory/write-back latch, and 00 takes the latch's own register value. When both later latches match, 01 wins.
- R7: Both selects are 00 in plain and split mode. The second select is 00 unless the execute latch holds an ALU operation (class 01).
- R8: A latch whose write enable is 0 never causes a stall, a forward or a write-through, whatever its destination field holds.
- R9: Register 0 is an ordinary register and takes part in every comparison.
- R10: `hold_fetch`, `hold_decode` and `bubble_ex` are always equal.
- R11: Running the sequence load R0; R0=R0+R0; R2=R2-R0 through a simple pipeline model takes 8 cycles from the first fetch to the last write-back in forward mode, 11 in split mode and 13 in plain mode.
- R12: A write-through flag is 1 only in split or forward mode, and only when the write-back latch writes a register that decode reads on that operand.

Class encoding used by all requirements: 00 is a no-op and reads nothing, 01 is ALU and reads both sources, 10 is load and reads the first source, 11 is store and reads the first source (address) and the second source (data).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the embedded property checks |
| rst | input | 1 | Synchronous active-high reset; forces all outputs quiet |
| mode | input | 2 | Hazard policy: 00 plain, 01 split, 1x forward |
| id_cls | input | 2 | Class of the instruction in decode |
| id_rs1 | input | RW | First source register in decode |
| id_rs2 | input | RW | Second source register in decode |
| ex_cls | input | 2 | Class of the instruction in execute |
| ex_we | input | 1 | Register write enable of the execute latch |
| ex_rd | input | RW | Destination of the execute latch |
| ex_rs1 | input | RW | First source of the execute latch |
| ex_rs2 | input | RW | Second source of the execute latch |
| mem_we | input | 1 | Register write enable of the execute/memory latch |
| mem_rd | input | RW | Destination of the execute/memory latch |
| wb_we | input | 1 | Register write enable of the memory/write-back latch |
| wb_rd | input | RW | Destination of the memory/write-back latch |
| hold_fetch | output | 1 | Keep the fetch address this cycle |
| hold_decode | output | 1 | Keep the decode latch this cycle |
| bubble_ex | output | 1 | Load a no-op into the execute latch |
| sel_a | output | 2 | Source select for the first execute operand |
| sel_b | output | 2 | Source select for the second execute operand |
| rf_wt_a | output | 1 | Decode first operand takes the value being written back |
| rf_wt_b | output | 1 | Decode second operand takes the value being written back |

## Verification
The hardest case to reach is a store whose data register is being written by an ALU operation one or two slots ahead, in forward mode. The same register fields on an ALU consumer would pass without any stall, so the store rule shows up only when class, slot and policy line up together. The bench reaches this case and its neighbours with a sweep over every policy, every decode class and every combination of latch write enable, destination and class in a four-register configuration. It compares each output against arithmetic expectations. It also drives a small behavioural pipeline through the load-add-subtract sequence to measure the cycle totals.

// File: rtl/hz_pkg.sv
package hz_pkg;

    typedef enum logic [1:0] {
        CLS_NOP   = 2'd0,
        CLS_ALU   = 2'd1,
        CLS_LOAD  = 2'd2,
        CLS_STORE = 2'd3
    } icls_e;

    typedef enum logic [1:0] {
        SEL_RF    = 2'd0,
        SEL_EXMEM = 2'd1,
        SEL_MEMWB = 2'd2
    } opsel_e;

    typedef struct packed {
        logic in_ex;
        logic in_mem;
        logic in_wb;
    } hits_t;

    localparam logic [1:0] MODE_PLAIN = 2'b00;
    localparam logic [1:0] MODE_SPLIT = 2'b01;

    function automatic logic mode_fwd(input logic [1:0] m);
        return m[1];
    endfunction

    function automatic logic mode_split_rd(input logic [1:0] m);
        return m != MODE_PLAIN;
    endfunction

    function automatic logic reads_a(input icls_e c);
        return c != CLS_NOP;
    endfunction

    function automatic logic reads_b(input icls_e c);
        return (c == CLS_ALU) || (c == CLS_STORE);
    endfunction

    // Second operand of a store is data, fetched in decode only.
    function automatic logic b_forwardable(input icls_e c);
        return c == CLS_ALU;
    endfunction

endpackage

// File: rtl/hz_match.sv
module hz_match
    import hz_pkg::*;
#(
    parameter int RW = 3
) (
    input  logic [RW-1:0] src,
    input  logic          used,
    input  logic          ex_we,
    input  logic [RW-1:0] ex_rd,
    input  logic          mem_we,
    input  logic [RW-1:0] mem_rd,
    input  logic          wb_we,
    input  logic [RW-1:0] wb_rd,
    output hits_t         hits
);

    always_comb begin
        hits.in_ex  = used && ex_we  && (ex_rd  == src);
        hits.in_mem = used && mem_we && (mem_rd == src);
        hits.in_wb  = used && wb_we  && (wb_rd  == src);
    end

endmodule

// File: rtl/hz_src_gate.sv
module hz_src_gate
    import hz_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode,
    input  hits_t      hits,
    input  logic       fwdable,
    input  logic       ex_is_load,
    output logic       stall,
    output logic       wt
);

    always_comb begin
        wt = mode_split_rd(mode) && hits.in_wb;
        if (mode_fwd(mode) && fwdable)
            stall = hits.in_ex && ex_is_load;
        else if (mode_split_rd(mode))
            stall = hits.in_ex || hits.in_mem;
        else
            stall = hits.in_ex || hits.in_mem || hits.in_wb;
    end

    assert_plain_wb_R2: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_PLAIN && hits.in_wb) |-> (stall && !wt));

    assert_split_wb_R3: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SPLIT && !hits.in_ex && !hits.in_mem && hits.in_wb) |-> (!stall && wt));

    assert_loaduse_R4: assert property (@(posedge clk) disable iff (rst)
        (mode_fwd(mode) && fwdable && hits.in_ex && ex_is_load) |-> stall);

    assert_alu_pass_R4: assert property (@(posedge clk) disable iff (rst)
        (mode_fwd(mode) && fwdable && !ex_is_load) |-> !stall);

endmodule

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick
    import hz_pkg::*;
#(
    parameter int RW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [RW-1:0] src,
    input  logic          mem_we,
    input  logic [RW-1:0] mem_rd,
    input  logic          wb_we,
    input  logic [RW-1:0] wb_rd,
    output opsel_e        sel
);

    logic hit_m, hit_w;

    always_comb begin
        hit_m = en && mem_we && (mem_rd == src);
        hit_w = en && wb_we  && (wb_rd  == src);
        if (hit_m)      sel = SEL_EXMEM;
        else if (hit_w) sel = SEL_MEMWB;
        else            sel = SEL_RF;
    end

    assert_prio_R6: assert property (@(posedge clk) disable iff (rst)
        (en && mem_we && wb_we && mem_rd == src && wb_rd == src) |-> (sel == SEL_EXMEM));

    assert_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !en |-> (sel == SEL_RF));

endmodule

// File: rtl/hazard_ctl.sv
module hazard_ctl
    import hz_pkg::*;
#(
    parameter int NREG = 8,
    localparam int RW = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    mode,
    input  logic [1:0]    id_cls,
    input  logic [RW-1:0] id_rs1,
    input  logic [RW-1:0] id_rs2,
    input  logic [1:0]    ex_cls,
    input  logic          ex_we,
    input  logic [RW-1:0] ex_rd,
    input  logic [RW-1:0] ex_rs1,
    input  logic [RW-1:0] ex_rs2,
    input  logic          mem_we,
    input  logic [RW-1:0] mem_rd,
    input  logic          wb_we,
    input  logic [RW-1:0] wb_rd,
    output logic          hold_fetch,
    output logic          hold_decode,
    output logic          bubble_ex,
    output logic [1:0]    sel_a,
    output logic [1:0]    sel_b,
    output logic          rf_wt_a,
    output logic          rf_wt_b
);

    localparam int NOPS = 2;

    icls_e         id_c, ex_c;
    logic [RW-1:0] dsrc  [NOPS];
    logic [RW-1:0] xsrc  [NOPS];
    logic          dused [NOPS];
    logic          dfwd  [NOPS];
    logic          xen   [NOPS];
    hits_t         dhits [NOPS];
    logic          dstall[NOPS];
    logic          dwt   [NOPS];
    opsel_e        xsel  [NOPS];
    logic          ex_is_load;
    logic          stall_any;

    assign id_c       = icls_e'(id_cls);
    assign ex_c       = icls_e'(ex_cls);
    assign ex_is_load = (ex_c == CLS_LOAD);

    assign dsrc[0]  = id_rs1;
    assign dsrc[1]  = id_rs2;
    assign dused[0] = reads_a(id_c);
    assign dused[1] = reads_b(id_c);
    assign dfwd[0]  = 1'b1;
    assign dfwd[1]  = b_forwardable(id_c);

    assign xsrc[0]  = ex_rs1;
    assign xsrc[1]  = ex_rs2;
    assign xen[0]   = mode_fwd(mode) && reads_a(ex_c);
    assign xen[1]   = mode_fwd(mode) && b_forwardable(ex_c);

    for (genvar k = 0; k < NOPS; k++) begin : g_opnd
        hz_match #(.RW(RW)) u_match (
            .src    (dsrc[k]),
            .used   (dused[k]),
            .ex_we  (ex_we),
            .ex_rd  (ex_rd),
            .mem_we (mem_we),
            .mem_rd (mem_rd),
            .wb_we  (wb_we),
            .wb_rd  (wb_rd),
            .hits   (dhits[k])
        );

        hz_src_gate u_gate (
            .clk        (clk),
            .rst        (rst),
            .mode       (mode),
            .hits       (dhits[k]),
            .fwdable    (dfwd[k]),
            .ex_is_load (ex_is_load),
            .stall      (dstall[k]),
            .wt         (dwt[k])
        );

        hz_fwd_pick #(.RW(RW)) u_pick (
            .clk    (clk),
            .rst    (rst),
            .en     (xen[k]),
            .src    (xsrc[k]),
            .mem_we (mem_we),
            .mem_rd (mem_rd),
            .wb_we  (wb_we),
            .wb_rd  (wb_rd),
            .sel    (xsel[k])
        );
    end

    always_comb begin
        stall_any   = !rst && (dstall[0] || dstall[1]);
        hold_fetch  = stall_any;
        hold_decode = stall_any;
        bubble_ex   = stall_any;
        sel_a       = rst ? SEL_RF : xsel[0];
        sel_b       = rst ? SEL_RF : xsel[1];
        rf_wt_a     = !rst && dwt[0];
        rf_wt_b     = !rst && dwt[1];
    end

    assert_store_data_R5: assert property (@(posedge clk) disable iff (rst)
        (mode != MODE_PLAIN && id_c == CLS_STORE && mem_we && mem_rd == id_rs2) |-> hold_decode);

    assert_no_we_R8: assert property (@(posedge clk) disable iff (rst)
        (!ex_we && !mem_we && !wb_we) |->
        (!hold_decode && sel_a == 2'd0 && sel_b == 2'd0 && !rf_wt_a && !rf_wt_b));

    assert_sel_b_R7: assert property (@(posedge clk) disable iff (rst)
        (ex_c != CLS_ALU) |-> (sel_b == 2'd0));

    assert_wt_off_R12: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_PLAIN) |-> (!rf_wt_a && !rf_wt_b));

endmodule

// File: tb/hazard_ctl_tb.sv
module hazard_ctl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NREG = 4;
    localparam int RW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    mode = 2'd0;
    logic [1:0]    id_cls = 2'd0, ex_cls = 2'd0;
    logic [RW-1:0] id_rs1 = '0, id_rs2 = '0, ex_rd = '0, ex_rs1 = '0, ex_rs2 = '0;
    logic [RW-1:0] mem_rd = '0, wb_rd = '0;
    logic          ex_we = 1'b0, mem_we = 1'b0, wb_we = 1'b0;
    logic          hold_fetch, hold_decode, bubble_ex, rf_wt_a, rf_wt_b;
    logic [1:0]    sel_a, sel_b;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hazard_ctl #(.NREG(NREG)) u_dut (
        .clk(clk), .rst(rst), .mode(mode),
        .id_cls(id_cls), .id_rs1(id_rs1), .id_rs2(id_rs2),
        .ex_cls(ex_cls), .ex_we(ex_we), .ex_rd(ex_rd), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
        .mem_we(mem_we), .mem_rd(mem_rd), .wb_we(wb_we), .wb_rd(wb_rd),
        .hold_fetch(hold_fetch), .hold_decode(hold_decode), .bubble_ex(bubble_ex),
        .sel_a(sel_a), .sel_b(sel_b), .rf_wt_a(rf_wt_a), .rf_wt_b(rf_wt_b)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected stall for one decode operand, from the policy rules.
    function automatic bit exp_stall(input int m, input bit used, input bit fwdable, input int r);
        bit hx, hm, hw;
        hx = used && ex_we  && (int'(ex_rd)  == r);
        hm = used && mem_we && (int'(mem_rd) == r);
        hw = used && wb_we  && (int'(wb_rd)  == r);
        if (m == 0) return hx || hm || hw;
        if (m == 1) return hx || hm;
        if (fwdable) return hx && (ex_cls == 2'd2);
        return hx || hm;
    endfunction

    function automatic int exp_sel(input int m, input bit used, input int r);
        if (m < 2 || !used) return 0;
        if (mem_we && int'(mem_rd) == r) return 1;
        if (wb_we && int'(wb_rd) == r) return 2;
        return 0;
    endfunction

    task automatic sweep();
        for (int m = 0; m < 4; m++)
        for (int c = 0; c < 4; c++)
        for (int a = 0; a < 2; a++)
        for (int b = 0; b < 2; b++)
        for (int e = 0; e < 16; e++)
        for (int mm = 0; mm < 4; mm++)
        for (int w = 0; w < 4; w++) begin
            bit ua, ub, fb, sa, sb, st, nowe;
            int ea, eb;
            string tg;
            @(negedge clk);
            mode   = 2'(m);
            id_cls = 2'(c);
            id_rs1 = RW'(a);
            id_rs2 = RW'(b);
            ex_we  = e[0];
            ex_rd  = RW'(e[1]);
            ex_cls = 2'(e >> 2);
            ex_rs1 = RW'(b);
            ex_rs2 = RW'(a);
            mem_we = mm[0];
            mem_rd = RW'(mm[1]);
            wb_we  = w[0];
            wb_rd  = RW'(w[1]);
            #1;
            ua = (c != 0);
            ub = (c == 1) || (c == 3);
            fb = (c == 1);
            sa = exp_stall(m, ua, 1'b1, a);
            sb = exp_stall(m, ub, fb, b);
            st = sa || sb;
            nowe = !ex_we && !mem_we && !wb_we;
            if (nowe)      tg = "R8 hold";
            else if (m == 0) tg = "R2 hold";
            else if (m == 1) tg = "R3 hold";
            else if (c == 3) tg = "R5 hold";
            else           tg = "R4 hold";
            check(tg, int'(hold_decode), int'(st));
            check("R10 hold_fetch", int'(hold_fetch), int'(hold_decode));
            check("R10 bubble_ex", int'(bubble_ex), int'(hold_decode));
            check("R12 rf_wt_a", int'(rf_wt_a),
                  int'(m != 0 && ua && wb_we && int'(wb_rd) == a));
            check("R12 rf_wt_b", int'(rf_wt_b),
                  int'(m != 0 && ub && wb_we && int'(wb_rd) == b));
            ea = exp_sel(m, ex_cls != 2'd0, b);
            eb = exp_sel(m, ex_cls == 2'd1, a);
            check(m >= 2 ? "R6 sel_a" : "R7 sel_a", int'(sel_a), ea);
            check(m >= 2 ? "R6 sel_b" : "R7 sel_b", int'(sel_b), eb);
        end
    endtask

    // Behavioural five-stage pipeline model: returns cycles from first fetch to last write-back.
    typedef struct packed {
        logic [1:0]    cls;
        logic          we;
        logic [RW-1:0] rd;
        logic [RW-1:0] rs1;
        logic [RW-1:0] rs2;
        logic [1:0]    tag;
    } ins_t;

    task automatic run_seq(input int m, input int exp_cycles, input string tg);
        ins_t prog [3];
        ins_t ifid, idex, exmem, memwb, nop;
        int pc, t, total;
        nop = '0;
        prog[0] = '{cls:2'd2, we:1'b1, rd:2'd0, rs1:2'd3, rs2:2'd0, tag:2'd1};
        prog[1] = '{cls:2'd1, we:1'b1, rd:2'd0, rs1:2'd0, rs2:2'd0, tag:2'd2};
        prog[2] = '{cls:2'd1, we:1'b1, rd:2'd2, rs1:2'd2, rs2:2'd0, tag:2'd3};
        ifid = nop; idex = nop; exmem = nop; memwb = nop;
        pc = 0; t = 0; total = -1;
        mode = 2'(m);
        while (total < 0 && t < 40) begin
            @(negedge clk);
            t++;
            id_cls = ifid.cls;  id_rs1 = ifid.rs1;  id_rs2 = ifid.rs2;
            ex_cls = idex.cls;  ex_we = idex.we;    ex_rd = idex.rd;
            ex_rs1 = idex.rs1;  ex_rs2 = idex.rs2;
            mem_we = exmem.we;  mem_rd = exmem.rd;
            wb_we  = memwb.we;  wb_rd  = memwb.rd;
            #1;
            if (memwb.tag == 2'd3) total = t;
            memwb = exmem;
            exmem = idex;
            if (hold_decode) begin
                idex = nop;
            end else begin
                idex = ifid;
                ifid = (pc < 3) ? prog[pc] : nop;
                pc++;
            end
        end
        check(tg, total, exp_cycles);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=expired expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: reset quiets every output despite conflicting inputs
        @(negedge clk);
        rst = 1'b1; mode = 2'd0; id_cls = 2'd1; id_rs1 = 2'd1; id_rs2 = 2'd1;
        ex_cls = 2'd2; ex_we = 1'b1; ex_rd = 2'd1; ex_rs1 = 2'd1; ex_rs2 = 2'd1;
        mem_we = 1'b1; mem_rd = 2'd1; wb_we = 1'b1; wb_rd = 2'd1;
        #1;
        check("R1 hold", int'(hold_decode), 0);
        check("R1 bubble", int'(bubble_ex), 0);
        mode = 2'd2; ex_cls = 2'd1;
        #1;
        check("R1 sel_a", int'(sel_a), 0);
        check("R1 rf_wt_a", int'(rf_wt_a), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R9: register 0 is compared like any other
        mode = 2'd2; id_cls = 2'd1; id_rs1 = 2'd0; id_rs2 = 2'd3;
        ex_cls = 2'd2; ex_we = 1'b1; ex_rd = 2'd0; ex_rs1 = 2'd0; ex_rs2 = 2'd3;
        mem_we = 1'b0; mem_rd = 2'd0; wb_we = 1'b0; wb_rd = 2'd0;
        #1;
        check("R9 load-use on r0", int'(hold_decode), 1);
        @(negedge clk);
        ex_cls = 2'd1; ex_we = 1'b0; mem_we = 1'b1; mem_rd = 2'd0;
        #1;
        check("R9 forward r0", int'(sel_a), 1);

        // R5 focused: store data behind ALU in forward mode stalls, ALU consumer does not
        @(negedge clk);
        mode = 2'd2; id_cls = 2'd3; id_rs1 = 2'd1; id_rs2 = 2'd2;
        ex_cls = 2'd1; ex_we = 1'b1; ex_rd = 2'd2; mem_we = 1'b0; wb_we = 1'b0;
        #1;
        check("R5 store data stall", int'(hold_decode), 1);
        id_cls = 2'd1;
        #1;
        check("R5 alu no stall", int'(hold_decode), 0);

        sweep();

        run_seq(2, 8,  "R11 forward cycles");
        run_seq(3, 8,  "R11 forward alt code cycles");
        run_seq(1, 11, "R11 split cycles");
        run_seq(0, 13, "R11 plain cycles");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule